// File: doc/BRIEF.md
# Triple countdown timer with watchdog

A word-addressed timer peripheral holding two general-purpose down-counters and a watchdog down-counter. Every counter steps down by one on each system clock while enabled. A single control word carries an enable bit and an auto-reload bit for each counter. Each counter has a reload register and a live count register. Software can overwrite the live count at any time, either to kick the watchdog or to schedule the next expiry of timer 0.

When a running counter steps from one to zero, it expires. With auto-reload set, the counter takes its reload value on the following clock, so a reload value R gives a period of R+1 cycles. With auto-reload clear, the counter stays at zero and expires only once. Expiries of timer 0 and timer 1 set sticky interrupt flags, which software clears by writing ones. A watchdog expiry issues a one-cycle reset request, but only while a separate reset-output enable input is high.

A free-running counter loaded with all ones and set to auto-reload works as a cycle counter: the bitwise inverse of its read value rises by one per clock.

Top module: `timer_top`

## Requirements
- R1: After reset, the control word, every reload and count register and both interrupt flags read zero, and `irq0`, `irq1` and `wdReq` are low.
- R2: While a counter's enable bit is set and its count is nonzero, the count drops by exactly one per clock. While the enable bit is clear, the count holds its value and the counter produces no event.
- R3: A running counter with auto-reload set that sits at zero takes its reload value on the next clock. An expiry occurs only on the step from one to zero.
- R4: A running counter with auto-reload clear stays at zero after it expires and raises no further event.
- R5: A write to a count register replaces the live count on that clock, taking priority over counting. Reading a count register returns the live count.
- R6: Control word bit layout: bit 0 enables timer 0, bit 1 is timer 0 auto-reload, bit 2 enables timer 1, bit 3 is timer 1 auto-reload, bit 4 enables the watchdog, bit 5 is watchdog auto-reload. The control word reads back as written.
- R7: Status register at byte offset 0x28: bit 0 is the timer 0 flag (driven on `irq0`) and bit 1 is the timer 1 flag (driven on `irq1`). A flag becomes 1 on the same clock that its count becomes zero. Writing 1 to a bit clears that flag. An expiry on the same clock as a clear leaves the flag set.
- R8: Writing zero to the control word stops all three counters, and their counts hold from then on.
- R9: A watchdog expiry raises `wdReq` for exactly one clock, on the clock where the watchdog count becomes zero, and only if `wdRstEn` was high in the cycle before that edge.
- R10: Byte offsets are: control 0x00, timer 0 reload 0x10, timer 0 count 0x14, timer 1 reload 0x18, timer 1 count 0x1C, watchdog reload 0x20, watchdog count 0x24. The unused words 0x04 to 0x0C read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counters step on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the word at `addr` |
| addr | input | AW | Byte address of the register accessed |
| wrData | input | DW | Write data |
| rdData | output | DW | Read data for `addr` (combinational) |
| wdRstEn | input | 1 | Lets a watchdog expiry drive `wdReq` |
| irq0 | output | 1 | Sticky timer 0 expiry flag |
| irq1 | output | 1 | Sticky timer 1 expiry flag |
| wdReq | output | 1 | One-cycle watchdog reset request |

## Verification
The bench builds the block with its defaults: a 32-bit data width and a 6-bit byte address. The full width lets the all-ones cycle-counter load and its reload path be exercised exactly as software would use them. Counts of two to five keep every expiry, reload and flag-clear collision within a few clocks, so each edge can be checked at the exact cycle it should occur. The bench also drives the reset-output enable both ways around a watchdog expiry, and kicks the watchdog just before it expires.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int NUM_TMR    = 3;
  localparam int WD_IDX     = 2;
  localparam int NUM_IRQ    = 2;
  localparam int CTRL_W     = 2 * NUM_TMR;
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_TMR    = 'h10;
  localparam int TMR_STRIDE = 8;
  localparam int CNT_OFS    = 4;
  localparam int OFF_STATUS = 'h28;

  // strobes and levels handed from control to datapath, one bit per counter
  typedef struct packed {
    logic [NUM_TMR-1:0] wrReload;
    logic [NUM_TMR-1:0] wrCount;
    logic [NUM_TMR-1:0] run;
    logic [NUM_TMR-1:0] autoLd;
  } tmrStrb_t;
endpackage

// File: rtl/timer_dp.sv
module timer_dp
  import timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  tmrStrb_t      strb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] cntQ    [NUM_TMR],
  output logic [DW-1:0] reloadQ [NUM_TMR],
  output logic [NUM_TMR-1:0] expire
);
  for (genvar g = 0; g < NUM_TMR; g++) begin : gTmr
    logic [DW-1:0] cnt;
    logic [DW-1:0] rel;

    // expiry is the step from one to zero; a software load masks it
    assign expire[g]  = strb.run[g] && !strb.wrCount[g] && (cnt == DW'(1));
    assign cntQ[g]    = cnt;
    assign reloadQ[g] = rel;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
        rel <= '0;
      end else begin
        if (strb.wrReload[g]) rel <= wrData;
        if (strb.wrCount[g]) begin
          cnt <= wrData;
        end else if (strb.run[g]) begin
          if (cnt != '0)          cnt <= cnt - DW'(1);
          else if (strb.autoLd[g]) cnt <= rel;
        end
      end
    end
  end
endmodule

// File: rtl/timer_ctl.sv
module timer_ctl
  import timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [AW-1:0]      addr,
  input  logic [CTRL_W-1:0]  wrLow,
  input  logic               wdRstEn,
  input  logic [NUM_TMR-1:0] expire,
  input  logic [DW-1:0]      cntIn    [NUM_TMR],
  input  logic [DW-1:0]      reloadIn [NUM_TMR],
  output tmrStrb_t           strb,
  output logic [DW-1:0]      rdData,
  output logic [NUM_IRQ-1:0] irqFlags,
  output logic               wdReq
);
  function automatic logic [AW-1:0] relAddr(int i);
    return AW'(OFF_TMR + TMR_STRIDE * i);
  endfunction

  function automatic logic [AW-1:0] cntAddr(int i);
    return AW'(OFF_TMR + TMR_STRIDE * i + CNT_OFS);
  endfunction

  logic [CTRL_W-1:0]  ctrlQ;
  logic [NUM_IRQ-1:0] flagQ;
  logic               wdReqQ;
  logic               wrCtrl;
  logic               wrStat;
  logic [NUM_IRQ-1:0] clrMask;

  assign wrCtrl  = wrEn && (addr == AW'(OFF_CTRL));
  assign wrStat  = wrEn && (addr == AW'(OFF_STATUS));
  assign clrMask = wrStat ? wrLow[NUM_IRQ-1:0] : '0;

  always_comb begin
    for (int i = 0; i < NUM_TMR; i++) begin
      strb.wrReload[i] = wrEn && (addr == relAddr(i));
      strb.wrCount[i]  = wrEn && (addr == cntAddr(i));
      strb.run[i]      = ctrlQ[2*i];
      strb.autoLd[i]   = ctrlQ[2*i+1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      flagQ  <= '0;
      wdReqQ <= 1'b0;
    end else begin
      if (wrCtrl) ctrlQ <= wrLow;
      flagQ  <= (flagQ & ~clrMask) | expire[NUM_IRQ-1:0];
      wdReqQ <= expire[WD_IDX] && wdRstEn;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == AW'(OFF_CTRL))   rdData = DW'(ctrlQ);
    if (addr == AW'(OFF_STATUS)) rdData = DW'(flagQ);
    for (int i = 0; i < NUM_TMR; i++) begin
      if (addr == relAddr(i)) rdData = reloadIn[i];
      if (addr == cntAddr(i)) rdData = cntIn[i];
    end
  end

  assign irqFlags = flagQ;
  assign wdReq    = wdReqQ;
endmodule

// File: rtl/timer_top.sv
module timer_top
  import timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic          wdRstEn,
  output logic          irq0,
  output logic          irq1,
  output logic          wdReq
);
  tmrStrb_t           strb;
  logic [DW-1:0]      cnt    [NUM_TMR];
  logic [DW-1:0]      reload [NUM_TMR];
  logic [NUM_TMR-1:0] expire;
  logic [NUM_IRQ-1:0] irqFlags;

  timer_ctl #(.DW(DW), .AW(AW)) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrLow    (wrData[CTRL_W-1:0]),
    .wdRstEn  (wdRstEn),
    .expire   (expire),
    .cntIn    (cnt),
    .reloadIn (reload),
    .strb     (strb),
    .rdData   (rdData),
    .irqFlags (irqFlags),
    .wdReq    (wdReq)
  );

  timer_dp #(.DW(DW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .cntQ    (cnt),
    .reloadQ (reload),
    .expire  (expire)
  );

  assign irq0 = irqFlags[0];
  assign irq1 = irqFlags[1];
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [AW-1:0] addr,
  input logic          clrBit,
  input logic          wdRstEn,
  input logic          irq0,
  input logic          wdReq,
  input logic          run0,
  input logic          autoLd0,
  input logic [DW-1:0] cnt0,
  input logic [DW-1:0] rel0
);
  logic wrCnt0;
  logic clr0;
  assign wrCnt0 = wrEn && (addr == AW'('h14));
  assign clr0   = wrEn && (addr == AW'('h28)) && clrBit;

  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!run0 && !wrCnt0) |=> $stable(cnt0)) else $error("R2 hold");

  assert_dec_by_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (run0 && cnt0 != '0 && !wrCnt0) |=> (cnt0 == $past(cnt0) - DW'(1))) else $error("R2 step");

  assert_reload_at_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (run0 && autoLd0 && cnt0 == '0 && !wrCnt0) |=> (cnt0 == $past(rel0))) else $error("R3 reload");

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irq0 && !clr0) |=> irq0) else $error("R7 sticky");

  assert_wd_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    wdReq |=> !wdReq) else $error("R9 pulse width");

  assert_wd_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    wdReq |-> $past(wdRstEn)) else $error("R9 gating");
endmodule

bind timer_top timer_chk #(.DW(DW), .AW(AW)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .clrBit  (wrData[0]),
  .wdRstEn (wdRstEn),
  .irq0    (irq0),
  .wdReq   (wdReq),
  .run0    (strb.run[0]),
  .autoLd0 (strb.autoLd[0]),
  .cnt0    (cnt[0]),
  .rel0    (reload[0])
);

// File: tb/sim_timer_top.sv
`timescale 1ns/1ps
module sim_timer_top;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_CTRL = 'h00, A_RES = 'h08, A_REL0 = 'h10, A_CNT0 = 'h14,
                            A_REL1 = 'h18, A_CNT1 = 'h1C, A_RELW = 'h20, A_CNTW = 'h24,
                            A_STAT = 'h28;
  localparam int S_RD = 0, S_IRQ0 = 1, S_IRQ1 = 2, S_WD = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic wdRstEn = 1'b0;
  logic irq0, irq1, wdReq;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  bit done = 1'b0;

  int          selQ [$];
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #2 clk = ~clk;

  timer_top #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .wdRstEn(wdRstEn), .irq0(irq0), .irq1(irq1), .wdReq(wdReq)
  );

  // monitor: compares one queued expectation per falling edge
  always @(negedge clk) begin
    if (selQ.size() != 0) begin
      int s;
      logic [31:0] e, a;
      string t;
      s = selQ.pop_front();
      e = expQ.pop_front();
      t = tagQ.pop_front();
      case (s)
        S_RD:    a = rdData;
        S_IRQ0:  a = {31'b0, irq0};
        S_IRQ1:  a = {31'b0, irq1};
        default: a = {31'b0, wdReq};
      endcase
      nChk++;
      if (a !== e) begin
        nFail++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  // watchdog for the bench itself
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      nFail++;
      nChk++;
      $display("FAIL timeout: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: queue the expectation, hold the address through the sample
  task automatic chk(input int s, input logic [AW-1:0] a, input logic [31:0] e, input string t);
    addr = a;
    selQ.push_back(s); expQ.push_back(e); tagQ.push_back(t);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    chk(S_RD, A_CTRL, 0, "R1 ctrl");
    chk(S_RD, A_CNT0, 0, "R1 count0");
    chk(S_RD, A_RELW, 0, "R1 wd reload");
    chk(S_RD, A_STAT, 0, "R1 status");
    chk(S_IRQ0, A_STAT, 0, "R1 irq0");
    chk(S_WD, A_STAT, 0, "R1 wdReq");

    // R5 direct load, R2 hold while disabled
    wr(A_CNT0, 100);
    chk(S_RD, A_CNT0, 100, "R5 load count0");
    idle(3);
    chk(S_RD, A_CNT0, 100, "R2 hold disabled");
    // R2 decrement once enabled (R6 bit0)
    wr(A_CTRL, 32'h1);
    chk(S_RD, A_CNT0, 100, "R2 first enabled cycle");
    chk(S_RD, A_CNT0, 99, "R2 step one");
    idle(3);
    chk(S_RD, A_CNT0, 95, "R2 steady decrement");
    wr(A_CTRL, 0);

    // R4 one-shot expiry, R7 flag
    wr(A_CNT0, 3);
    wr(A_CTRL, 32'h1);
    idle(2);
    chk(S_IRQ0, A_STAT, 0, "R7 flag before expiry");
    chk(S_IRQ0, A_STAT, 1, "R7 flag at expiry");
    chk(S_RD, A_CNT0, 0, "R4 at zero");
    idle(4);
    chk(S_RD, A_CNT0, 0, "R4 stays zero");
    chk(S_RD, A_STAT, 1, "R7 status bit0");
    wr(A_STAT, 1);
    chk(S_IRQ0, A_STAT, 0, "R7 write-one clear");
    idle(4);
    chk(S_IRQ0, A_STAT, 0, "R4 no second event");

    // R3 auto-reload, R7 set beats clear
    wr(A_CTRL, 0);
    wr(A_STAT, 3);
    wr(A_REL0, 4);
    wr(A_CNT0, 2);
    wr(A_CTRL, 32'h3);
    idle(2);
    chk(S_RD, A_CNT0, 0, "R3 reaches zero");
    chk(S_RD, A_CNT0, 4, "R3 reload taken");
    chk(S_RD, A_CNT0, 3, "R3 counts from reload");
    wr(A_STAT, 1);
    chk(S_IRQ0, A_STAT, 0, "R7 cleared mid-period");
    chk(S_IRQ0, A_STAT, 1, "R3 period of reload plus one");
    idle(3);
    wr(A_STAT, 1);
    chk(S_IRQ0, A_STAT, 1, "R7 set wins over clear");
    wr(A_CTRL, 0);
    wr(A_STAT, 3);

    // timer 1 as cycle counter, R10 offsets, R7 bit1
    wr(A_REL1, 32'hFFFF_FFFF);
    wr(A_CNT1, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'hC);
    idle(5);
    chk(S_RD, A_CNT1, 32'hFFFF_FFFA, "R5 live count1 read");
    wr(A_CNT1, 2);
    chk(S_IRQ1, A_STAT, 0, "R7 irq1 before expiry");
    chk(S_IRQ1, A_STAT, 0, "R7 irq1 one left");
    chk(S_IRQ1, A_STAT, 1, "R7 irq1 at expiry");
    chk(S_RD, A_CNT1, 32'hFFFF_FFFF, "R3 timer1 reload");
    chk(S_RD, A_STAT, 2, "R7 status bit1");
    chk(S_IRQ0, A_STAT, 0, "R6 timer0 idle");
    chk(S_RD, A_CTRL, 32'hC, "R6 ctrl readback");
    chk(S_RD, A_RES, 0, "R10 reserved word");
    chk(S_RD, A_REL1, 32'hFFFF_FFFF, "R10 reload1 offset");

    // R9 watchdog gating and pulse
    wr(A_CTRL, 0);
    wr(A_CNTW, 3);
    wr(A_CTRL, 32'h10);
    idle(3);
    chk(S_WD, A_STAT, 0, "R9 no pulse when output disabled");
    chk(S_RD, A_CNTW, 0, "R4 watchdog stopped at zero");
    wdRstEn = 1'b1;
    wr(A_CNTW, 3);
    idle(2);
    chk(S_WD, A_STAT, 0, "R9 before expiry");
    chk(S_WD, A_STAT, 1, "R9 pulse");
    chk(S_WD, A_STAT, 0, "R9 single cycle");
    wr(A_CNTW, 3);
    idle(1);
    wr(A_CNTW, 3);
    idle(2);
    chk(S_WD, A_STAT, 0, "R5 kick postpones expiry");
    chk(S_WD, A_STAT, 1, "R9 pulse after kick");
    wr(A_RELW, 32'h1234);
    chk(S_RD, A_RELW, 32'h1234, "R10 wd reload offset");

    // R8 control zero stops everything
    wr(A_CTRL, 0);
    wr(A_CNT0, 50);
    wr(A_CNT1, 60);
    wr(A_CNTW, 70);
    wr(A_CTRL, 32'h15);
    wr(A_CTRL, 0);
    idle(3);
    chk(S_RD, A_CNT0, 49, "R8 timer0 frozen");
    chk(S_RD, A_CNT1, 59, "R8 timer1 frozen");
    chk(S_RD, A_CNTW, 69, "R8 watchdog frozen");
    chk(S_WD, A_STAT, 0, "R8 no watchdog request");

    idle(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule